// File: doc/BRIEF.md
# Vectored Interrupt Controller with Pin Sense

This block collects the interrupt sources of a small microcontroller and turns them into a single request to the CPU. It also supplies the vector address the CPU should fetch. The sources are:

- a 128 µs tick and a 1.024 ms tick;
- a bus-reset / keyboard-port activity event;
- the serial-peripheral completion;
- two capture channels;
- a wake-up timer;
- a group of general-purpose pins.

Each of these sources has a pending latch and an enable bit. A pending, enabled source is a request. When several requests are present, a fixed priority picks one: the lowest vector address wins.

The general-purpose pins share one flag. Each pin is first qualified by its own enable bit and its own polarity bit. The qualified pins are ORed into one flip-flop, and the group's enable bit gates that flip-flop like any other source. A global enable stands between the requests and the CPU:

- a disable command clears it;
- an enable command sets it;
- a return-from-interrupt command sets it;
- taking an interrupt clears it.

When the CPU takes an interrupt, only the pending latch of the source that won is cleared.

Top module: `vic_top`

## Requirements
- R1: After a synchronous active-low reset, all pending latches, the pin flag and the global enable are clear, so `irq_req`, `irq_pend` and `gie` are 0 and `irq_vec` is 0x0000.
- R2: A one-cycle pulse on `src_evt` sets that source's pending latch at the next rising edge. The latch holds until the source is taken. The bit order of `src_evt` is: 0 = 128 µs tick, 1 = 1.024 ms tick, 2 = bus reset/activity, 3 = serial peripheral, 4 = capture A, 5 = capture B, 6 = wake-up.
- R3: `irq_pend` is high whenever any pending source is also enabled, whatever the state of the global enable. `irq_req` is `irq_pend` AND the global enable.
- R4: `irq_vec` gives the vector of the winning source. The vectors are: 128 µs 0x0002, 1.024 ms 0x0004, bus 0x000C, serial 0x000E, capture A 0x0010, capture B 0x0012, pins 0x0014, wake-up 0x0016. With no request, `irq_vec` is 0x0000.
- R5: Among pending, enabled sources, the one with the lowest vector address is presented.
- R6: `src_en` bit 0 to bit 5 follow the `src_evt` order, bit 6 enables the pin group and bit 7 enables wake-up. A source whose enable is 0 raises no request, but its latch keeps the event. The request appears as soon as the enable is set.
- R7: `cmd_di` clears the global enable. `cmd_ei` and `cmd_reti` set it. If both kinds arrive in the same cycle, disable wins.
- R8: `irq_ack` while `irq_req` is high takes the interrupt: it clears only the winning source's latch and clears the global enable, and this take overrides a same-cycle enable command. A new event of that same source in the same cycle keeps its latch set. `irq_ack` while `irq_req` is low has no effect.
- R9: A source that becomes pending while the global enable is off stays pending and is requested once the global enable returns.
- R10: Pin i is qualified when `gpio_pin_en[i]` is 1 and `gpio_pin[i]` equals `gpio_pol[i]` (1 = active high, 0 = active low). Any qualified pin sets the shared pin flag at the next edge. The flag raises a request only when `src_en` bit 6 is 1.
- R11: The pin flag stays set after the pin returns to idle. It is cleared only when the pin vector is taken.
- R12: All pins share vector 0x0014 and have no priority among themselves. A single take clears the flag no matter how many pins set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_evt | input | 7 | Event pulses of the non-pin sources |
| src_en | input | 8 | Per-source enables in priority order |
| gpio_pin | input | NPIN | Pin levels |
| gpio_pin_en | input | NPIN | Per-pin interrupt enable |
| gpio_pol | input | NPIN | Per-pin active level |
| cmd_ei | input | 1 | Enable-interrupts command |
| cmd_di | input | 1 | Disable-interrupts command |
| cmd_reti | input | 1 | Return-from-interrupt command |
| irq_ack | input | 1 | CPU takes the presented interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_pend | output | 1 | Some enabled source is pending |
| irq_vec | output | 16 | Vector address of the winner |
| gie | output | 1 | Global interrupt enable state |

## Verification
The hardest state to reach is a take that collides with other activity in the same cycle:

- an enable command arriving together with the acknowledge;
- a fresh event of the winning source arriving together with the acknowledge;
- a lower-priority source left waiting while the global enable is off.

The bench reaches these states by building up several pending sources while the global enable is off. It then drives the command and acknowledge inputs in the same cycle and reads the vector and pending status before and after each take. The pin flag's sticky behaviour is reached by pulsing a qualified pin and returning it to idle before checking.

// File: rtl/vic_pkg.sv
// Shared constants for the vectored interrupt controller.
// Sources are indexed in priority order: index 0 wins over every other index.
package vic_pkg;
    localparam int NSRC     = 8;   // sources seen by the priority encoder
    localparam int NEXT     = 7;   // sources that arrive as event pulses
    localparam int VEC_W    = 16;  // width of a vector address
    localparam int GPIO_IDX = 6;   // priority slot of the shared pin flag
    localparam int WAKE_IDX = 7;   // priority slot of the wake-up source

    // Vector table slot of a priority index; vectors sit two bytes apart.
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        int slot;
        slot = (idx < 2) ? idx + 1 : idx + 4;
        return VEC_W'(slot * 2);
    endfunction
endpackage

// File: rtl/vic_gpio_sense.sv
// Qualifies each pin by its enable and polarity bits and ORs the results
// into one shared flag. The flag is sticky until the pin vector is taken.
// Assumes the pins are already synchronous to clk.
module vic_gpio_sense #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin,
    input  logic [NPIN-1:0] pin_en,
    input  logic [NPIN-1:0] pol,
    input  logic            clr,
    output logic            flag
);
    logic [NPIN-1:0] qual;
    logic            hit;

    // A pin counts when it is enabled and sits at its active level.
    always_comb begin
        qual = pin_en & ~(pin ^ pol);
        hit  = |qual;
    end

    // Shared flag: set by any qualified pin, cleared by a take; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (hit)  flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    assert_pin_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    assert_flag_clears_on_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/vic_pend_bank.sv
// One pending latch per pulsed source. An event sets the latch and a take
// clears it; an event in the same cycle as a take keeps the latch set.
module vic_pend_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_latch
        // Latch for source i: event sets, take clears, event has precedence.
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (evt[i]) pend[i] <= 1'b1;
            else if (clr[i]) pend[i] <= 1'b0;
        end

        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> pend[i]);
        assert_take_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/vic_prio_enc.sv
// Fixed-priority encoder: the lowest index among the requests wins.
// Produces a one-hot grant and the winner's vector address.
// Purely combinational.
module vic_prio_enc
    import vic_pkg::*;
(
    input  logic [NSRC-1:0]  req,
    output logic [NSRC-1:0]  grant,
    output logic             any,
    output logic [VEC_W-1:0] vec
);
    // Scan from the lowest priority upward so the lowest index is left last.
    always_comb begin
        grant = '0;
        vec   = '0;
        any   = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = vec_of(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vic_gie_ctl.sv
// Global interrupt enable. Precedence: a take clears it, then a disable
// command clears it, then an enable or return command sets it.
module vic_gie_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ei,
    input  logic di,
    input  logic reti,
    input  logic take,
    output logic gie
);
    // Enable flag update in precedence order.
    always_ff @(posedge clk) begin
        if (!rst_n)          gie <= 1'b0;
        else if (take || di) gie <= 1'b0;
        else if (ei || reti) gie <= 1'b1;
    end

    assert_take_clears_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gie);
    assert_di_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        di |=> !gie);
    assert_ei_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ei || reti) && !di && !take) |=> gie);
endmodule

// File: rtl/vic_top.sv
// Vectored interrupt controller top.
// Merges the pulsed sources, the wake-up source and the shared pin flag
// into one priority-ordered request vector, gates it with the per-source
// enables, and presents the winner to the CPU behind the global enable.
// Assumes the CPU raises irq_ack for one cycle when it vectors.
module vic_top
    import vic_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  src_evt,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NPIN-1:0]  gpio_pin,
    input  logic [NPIN-1:0]  gpio_pin_en,
    input  logic [NPIN-1:0]  gpio_pol,
    input  logic             cmd_ei,
    input  logic             cmd_di,
    input  logic             cmd_reti,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic             irq_pend,
    output logic [VEC_W-1:0] irq_vec,
    output logic             gie
);
    logic [NEXT-1:0] ext_pend;
    logic [NEXT-1:0] ext_clr;
    logic            pin_flag;
    logic [NSRC-1:0] pend_all;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] clr_all;
    logic            any;
    logic            take;

    // Place each source in its priority slot and apply the enables.
    always_comb begin
        pend_all = {ext_pend[NEXT-1], pin_flag, ext_pend[NEXT-2:0]};
        req      = pend_all & src_en;
        take     = irq_ack && any && gie;
        clr_all  = grant & {NSRC{take}};
        ext_clr  = {clr_all[WAKE_IDX], clr_all[GPIO_IDX-1:0]};
    end

    vic_pend_bank #(.N(NEXT)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (src_evt),
        .clr  (ext_clr),
        .pend (ext_pend)
    );

    vic_gpio_sense #(.NPIN(NPIN)) u_gpio (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (gpio_pin),
        .pin_en(gpio_pin_en),
        .pol   (gpio_pol),
        .clr   (clr_all[GPIO_IDX]),
        .flag  (pin_flag)
    );

    vic_prio_enc u_enc (
        .req  (req),
        .grant(grant),
        .any  (any),
        .vec  (irq_vec)
    );

    vic_gie_ctl u_gie (
        .clk (clk),
        .rst_n(rst_n),
        .ei  (cmd_ei),
        .di  (cmd_di),
        .reti(cmd_reti),
        .take(take),
        .gie (gie)
    );

    // CPU-facing status and request.
    always_comb begin
        irq_pend = any;
        irq_req  = any && gie;
    end

    assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_no_higher_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req & (grant - NSRC'(1)) & {NSRC{|grant}}) == '0);
    assert_vec_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> (irq_vec != '0));
    assert_vec_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pend |-> (irq_vec == '0));
    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req) |=> $stable(pend_all & ~{1'b0, {NPIN > 0}, 6'b0}) || (|src_evt));
endmodule

// File: tb/vic_top_tb.sv
module vic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  src_evt;
    logic [7:0]  src_en;
    logic [7:0]  gpio_pin, gpio_pin_en, gpio_pol;
    logic        cmd_ei, cmd_di, cmd_reti, irq_ack;
    logic        irq_req, irq_pend, gie;
    logic [15:0] irq_vec;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #10 clk = ~clk;

    vic_top #(.NPIN(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_en(src_en),
        .gpio_pin(gpio_pin), .gpio_pin_en(gpio_pin_en), .gpio_pol(gpio_pol),
        .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_reti(cmd_reti), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_pend(irq_pend), .irq_vec(irq_vec), .gie(gie)
    );

    typedef struct packed {
        logic [7:0]  en;
        logic [6:0]  evt;
        logic [15:0] vec;
    } row_t;

    // Enables, event pulses and the vector expected afterwards (R4, R5, R6).
    localparam row_t TBL [12] = '{
        '{8'hFF, 7'h01, 16'h0002},
        '{8'hFF, 7'h02, 16'h0004},
        '{8'hFF, 7'h04, 16'h000C},
        '{8'hFF, 7'h08, 16'h000E},
        '{8'hFF, 7'h10, 16'h0010},
        '{8'hFF, 7'h20, 16'h0012},
        '{8'hFF, 7'h40, 16'h0016},
        '{8'hFF, 7'h7F, 16'h0002},
        '{8'hFE, 7'h03, 16'h0004},
        '{8'hFC, 7'h7F, 16'h000C},
        '{8'h00, 7'h7F, 16'h0000},
        '{8'h80, 7'h41, 16'h0016}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; src_evt = '0; src_en = '0; gpio_pin = '0;
        gpio_pin_en = '0; gpio_pol = '0; cmd_ei = 0; cmd_di = 0;
        cmd_reti = 0; irq_ack = 0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic pulse_evt(input logic [6:0] e);
        src_evt = e; tick(); src_evt = '0;
    endtask

    task automatic ei();   cmd_ei = 1;   tick(); cmd_ei = 0;   endtask
    task automatic di();   cmd_di = 1;   tick(); cmd_di = 0;   endtask
    task automatic reti(); cmd_reti = 1; tick(); cmd_reti = 0; endtask
    task automatic ack();  irq_ack = 1;  tick(); irq_ack = 0;  endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 0);
            summary();
            $finish;
        end
    end

    initial begin
        tick();
        do_reset();
        tick();
        check("R1 irq_req", irq_req, 0);
        check("R1 irq_pend", irq_pend, 0);
        check("R1 gie", gie, 0);
        check("R1 irq_vec", irq_vec, 0);

        // Vector table loop: each row from a clean reset.
        foreach (TBL[k]) begin
            do_reset();
            src_en = TBL[k].en;
            pulse_evt(TBL[k].evt);
            check($sformatf("R4 R5 R6 row %0d vec", k), irq_vec, TBL[k].vec);
            check($sformatf("R2 R3 row %0d pend", k), irq_pend, TBL[k].vec != 0);
            check($sformatf("R3 row %0d req gated", k), irq_req, 0);
        end

        // Global enable and take.
        do_reset(); src_en = 8'hFF;
        pulse_evt(7'h10);
        check("R3 req off while gie low", irq_req, 0);
        ei();
        check("R7 ei sets gie", gie, 1);
        check("R3 req with gie", irq_req, 1);
        ack();
        check("R8 take clears gie", gie, 0);
        check("R8 take clears latch", irq_pend, 0);
        check("R8 vec after take", irq_vec, 0);

        // Only the winner is cleared; the loser waits for the return.
        pulse_evt(7'h28);
        ei();
        check("R5 serial wins", irq_vec, 16'h000E);
        ack();
        check("R8 loser remains", irq_vec, 16'h0012);
        check("R9 loser held off", irq_req, 0);
        reti();
        check("R9 reti presents loser", irq_req, 1);
        check("R7 reti sets gie", gie, 1);

        // Ack while no request is raised is ignored.
        di();
        check("R7 di clears", gie, 0);
        ack();
        check("R8 idle ack keeps latch", irq_vec, 16'h0012);

        // Precedence of commands and takes.
        cmd_ei = 1; cmd_di = 1; tick(); cmd_ei = 0; cmd_di = 0;
        check("R7 di beats ei", gie, 0);
        ei();
        cmd_ei = 1; irq_ack = 1; tick(); cmd_ei = 0; irq_ack = 0;
        check("R8 take beats ei", gie, 0);
        check("R8 take with ei clears", irq_pend, 0);

        // New event of the winner during its take.
        pulse_evt(7'h40);
        ei();
        irq_ack = 1; src_evt = 7'h40; tick(); irq_ack = 0; src_evt = '0;
        check("R8 same-cycle event kept", irq_vec, 16'h0016);
        check("R8 gie after take", gie, 0);

        // Disabled source keeps its latch.
        do_reset(); src_en = 8'hEF;
        pulse_evt(7'h10);
        check("R6 disabled no pend", irq_pend, 0);
        src_en = 8'hFF; tick();
        check("R6 enable reveals latch", irq_vec, 16'h0010);

        // Pin group, active high.
        do_reset(); src_en = 8'hFF;
        gpio_pin_en = 8'h04; gpio_pol = 8'h04;
        gpio_pin = 8'hFB; tick();
        check("R10 disabled pins ignored", irq_pend, 0);
        gpio_pin = 8'h04; tick(); gpio_pin = 8'h00;
        check("R10 pin vec", irq_vec, 16'h0014);
        tick(); tick();
        check("R11 flag sticky", irq_pend, 1);
        src_en = 8'hBF; tick();
        check("R10 group enable gates", irq_pend, 0);
        src_en = 8'hFF; tick();
        check("R10 group enable restores", irq_vec, 16'h0014);
        ei(); ack();
        check("R11 take clears flag", irq_pend, 0);

        // Active low pin.
        gpio_pin_en = 8'h08; gpio_pol = 8'h00; gpio_pin = 8'hFF; tick();
        check("R10 inactive low pin", irq_pend, 0);
        gpio_pin = 8'hF7; tick(); gpio_pin = 8'hFF;
        check("R10 active low pin", irq_vec, 16'h0014);
        ei(); ack();
        check("R11 low pin cleared", irq_pend, 0);

        // Two pins share one flag and one take.
        gpio_pin_en = 8'h81; gpio_pol = 8'h81; gpio_pin = 8'h00; tick();
        gpio_pin = 8'h81; tick(); gpio_pin = 8'h00;
        check("R12 shared vec", irq_vec, 16'h0014);
        ei(); ack();
        check("R12 one take clears", irq_pend, 0);

        // Pins beat wake-up.
        pulse_evt(7'h40);
        gpio_pin = 8'h01; tick(); gpio_pin = 8'h00;
        check("R5 pins over wake", irq_vec, 16'h0014);

        summary();
        $finish;
    end
endmodule